// File: doc/BRIEF.md
# Two-Channel Carry-Out Sigma-Delta Pulse DAC

This block turns two 16-bit codes into two one-bit pulse streams whose long-run average follows each code. Every channel keeps a code register and an accumulator of the same width. On each modulator step the code is added into the accumulator, and the carry out of that sum becomes the channel's pulse bit. From a cleared accumulator, the number of carries after K steps is floor(K * code / 65536). An external RC filter on each pin recovers an analog level.

Both channels share one base clock and one enable tick. A three-state phase machine splits every modulator step into two tick-long halves. The states are IDLE (modulators stopped), FIRST (first half) and SECOND (second half). The transitions are named as follows:

- start: IDLE to FIRST, on a tick while active.
- split: FIRST to SECOND, on a tick.
- advance: SECOND to FIRST, on a tick.
- release: any state to IDLE, whenever the mode is off.

A step happens on start and on advance. In non-return-to-zero mode the pulse bit is held for both halves. In return-to-zero mode the bit is shown only in the first half, which halves the output range. In the off mode the pins carry the general-purpose port values instead. Codes are loaded a byte at a time through a small write port. A code takes effect only when its high byte is written.

Top module: `sd_dac_pair`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, both pins are low when the mode is 00 or 01. Both code registers reset to zero, so a run with no writes produces no high samples.
- R2: The write address selects a byte: 0 is the channel 0 low byte, 1 the channel 0 high byte, 2 the channel 1 low byte, 3 the channel 1 high byte. A low-byte write is only staged and does not change the active code. A high-byte write loads {high byte, staged low byte} into the channel's code in one cycle.
- R3: While active, the phase steps through FIRST and SECOND once per tick. The accumulators advance once per two ticks. From a cleared accumulator, K steps give floor(K * code / 65536) carries.
- R4: Mode 00 (non-return-to-zero) drives each pin with the channel's last carry for both halves of a step.
- R5: Mode 01 (return-to-zero) drives a carry high only during the FIRST half. The pin is low throughout SECOND.
- R6: In mode 01 with code 0x4010 starting from a cleared accumulator, the first four steps give per half-tick samples 0,0,0,0,0,0,1,0. Over 64 steps there are 16 high half-ticks.
- R7: Reduced-resolution codes work. Code 0x0100 gives one carry every 256 steps, and code 0x0010 gives one every 4096 steps.
- R8: Mode 1x (off) puts `port_in` on `pin_out`, clears both accumulators and carries, and returns the phase to IDLE. Re-enabling restarts the pulse pattern from its beginning.
- R9: On cycles without a tick, the phase, the accumulators and the active-mode pins hold.
- R10: The two channels run independently on their own codes but share one phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Prescaler enable; one tick is one half of a modulator step |
| mode | input | 2 | 00 non-return-to-zero, 01 return-to-zero, 1x off |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Byte select (see R2) |
| wr_data | input | 8 | Byte to write |
| port_in | input | 2 | General-purpose values shown on the pins when off |
| pin_out | output | 2 | Channel pulse outputs, bit 0 is channel 0 |

## Verification
The main function is tried with table rows that pair different codes on the two channels in both pulse shapes. Mid-scale, quarter, three-quarter, zero and full-scale codes give high-sample counts that separate a correct carry sum from an off-by-one or a dropped carry. Return-to-zero rows yield half the count of the matching non-return-to-zero rows, which exposes a missing second-half blanking. The 0x4010 pattern and the coarse 0x0100 and 0x0010 codes test exact carry placement over long spans. Directed runs cover byte staging, gapped ticks, pass-through when off, and restart after re-enable.

// File: rtl/sd_dac_pkg.sv
package sd_dac_pkg;

    // Output shaping selection; bit 1 set means the pins are released.
    typedef enum logic [1:0] {
        MODE_NRZ  = 2'b00,
        MODE_RZ   = 2'b01,
        MODE_OFF  = 2'b10,
        MODE_OFF2 = 2'b11
    } mode_e;

    // Shared modulator phase.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_FIRST  = 2'b01,
        PH_SECOND = 2'b10
    } phase_e;

    function automatic logic mode_is_off(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/sd_phase_fsm.sv
module sd_phase_fsm
    import sd_dac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   off,
    output phase_e phase,
    output logic   step,
    output logic   clear
);

    phase_e state_q;
    phase_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: start, split, advance, release.
    always_comb begin
        state_d = state_q;
        if (off) begin
            state_d = PH_IDLE;                  // release
        end else if (tick) begin
            unique case (state_q)
                PH_IDLE:   state_d = PH_FIRST;  // start
                PH_FIRST:  state_d = PH_SECOND; // split
                PH_SECOND: state_d = PH_FIRST;  // advance
                default:   state_d = PH_IDLE;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        phase = state_q;
        clear = off;
        step  = 1'b0;
        if (!off && tick) begin
            unique case (state_q)
                PH_IDLE:   step = 1'b1;
                PH_FIRST:  step = 1'b0;
                PH_SECOND: step = 1'b1;
                default:   step = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/sd_code_regs.sv
module sd_code_regs #(
    parameter int CH = 2,
    parameter int DW = 16,
    parameter int BW = 8,
    localparam int NB = DW / BW,
    localparam int AW = $clog2(CH * NB)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [BW-1:0]          wr_data,
    output logic [CH-1:0][DW-1:0]  code
);

    logic [CH-1:0][NB-2:0][BW-1:0] stage_q;

    for (genvar c = 0; c < CH; c++) begin : g_ch
        // Lower bytes are staged until the top byte arrives.
        for (genvar b = 0; b < NB - 1; b++) begin : g_low
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[c][b] <= '0;
                end else if (wr_en && wr_addr == AW'(c * NB + b)) begin
                    stage_q[c][b] <= wr_data;
                end
            end
        end

        // Top byte commits the whole code in one cycle.
        always_ff @(posedge clk) begin
            if (rst) begin
                code[c] <= '0;
            end else if (wr_en && wr_addr == AW'(c * NB + NB - 1)) begin
                code[c] <= {wr_data, stage_q[c]};
            end
        end
    end

endmodule

// File: rtl/sd_accum.sv
module sd_accum #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step,
    input  logic [DW-1:0] code,
    output logic          carry
);

    logic [DW-1:0] acc_q;
    logic [DW:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, code};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
            carry <= 1'b0;
        end else if (step) begin
            acc_q <= sum[DW-1:0];
            carry <= sum[DW];
        end
    end

endmodule

// File: rtl/sd_out_shaper.sv
module sd_out_shaper
    import sd_dac_pkg::*;
(
    input  logic [1:0] mode,
    input  phase_e     phase,
    input  logic       carry,
    input  logic       port_in,
    output logic       pin
);

    always_comb begin
        unique case (mode_e'(mode))
            MODE_NRZ:  pin = carry;
            MODE_RZ:   pin = carry && (phase == PH_FIRST);
            MODE_OFF:  pin = port_in;
            MODE_OFF2: pin = port_in;
            default:   pin = port_in;
        endcase
    end

endmodule

// File: rtl/sd_dac_pair.sv
module sd_dac_pair
    import sd_dac_pkg::*;
#(
    parameter int CH = 2,
    parameter int DW = 16,
    parameter int BW = 8,
    localparam int AW = $clog2(CH * (DW / BW))
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [1:0]    mode,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [BW-1:0] wr_data,
    input  logic [CH-1:0] port_in,
    output logic [CH-1:0] pin_out
);

    phase_e               phase;
    logic                 step;
    logic                 clear;
    logic [CH-1:0]        carry;
    logic [CH-1:0][DW-1:0] code;

    sd_phase_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .off   (mode_is_off(mode)),
        .phase (phase),
        .step  (step),
        .clear (clear)
    );

    sd_code_regs #(.CH(CH), .DW(DW), .BW(BW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .code    (code)
    );

    for (genvar c = 0; c < CH; c++) begin : g_chan
        sd_accum #(.DW(DW)) u_acc (
            .clk   (clk),
            .rst   (rst),
            .clear (clear),
            .step  (step),
            .code  (code[c]),
            .carry (carry[c])
        );

        sd_out_shaper u_shape (
            .mode    (mode),
            .phase   (phase),
            .carry   (carry[c]),
            .port_in (port_in[c]),
            .pin     (pin_out[c])
        );
    end

endmodule

// File: rtl/sd_dac_pair_chk.sv
module sd_dac_pair_chk
    import sd_dac_pkg::*;
#(
    parameter int CH = 2,
    parameter int DW = 16,
    parameter int BW = 8,
    parameter int AW = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tick,
    input logic [1:0]            mode,
    input logic                  wr_en,
    input logic [AW-1:0]         wr_addr,
    input logic [BW-1:0]         wr_data,
    input logic [CH-1:0]         pin_out,
    input phase_e                phase,
    input logic [CH-1:0]         carry,
    input logic [CH-1:0][DW-1:0] code
);

    localparam int NB = DW / BW;

    // R3: split and advance on every active tick.
    assert_split_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FIRST && tick && !mode[1]) |=> (phase == PH_SECOND));
    assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SECOND && tick && !mode[1]) |=> (phase == PH_FIRST));

    // R4: non-return-to-zero keeps the first-half level through the second half.
    assert_nrz_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FIRST && tick && mode == 2'b00) ##1 (mode == 2'b00)
            |-> (pin_out == $past(pin_out)));

    // R5: return-to-zero blanks the second half.
    assert_rz_blank_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SECOND && mode == 2'b01) |-> (pin_out == '0));

    // R8: off clears carries and parks the phase.
    assert_off_clear_R8: assert property (@(posedge clk) disable iff (rst)
        mode[1] |=> (phase == PH_IDLE && carry == '0));

    // R9: no tick, no change on the active pins.
    assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (rst)
        (!tick && !mode[1]) ##1 (!mode[1] && $stable(mode)) |-> $stable(pin_out));

    for (genvar c = 0; c < CH; c++) begin : g_chk
        // R2: only the top-byte write changes the active code.
        assert_code_hold_R2: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_addr == AW'(c * NB + NB - 1)) |=> $stable(code[c]));
        assert_code_commit_R2: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == AW'(c * NB + NB - 1))
                |=> (code[c][DW-1 -: BW] == $past(wr_data)));
    end

endmodule

bind sd_dac_pair sd_dac_pair_chk #(.CH(CH), .DW(DW), .BW(BW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .mode    (mode),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pin_out (pin_out),
    .phase   (phase),
    .carry   (carry),
    .code    (code)
);

// File: tb/sd_dac_pair_tb.sv
`timescale 1ns/1ps
module sd_dac_pair_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] port_in = '0;
    logic [1:0] pin_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sd_dac_pair u_dut (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .mode    (mode),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .port_in (port_in),
        .pin_out (pin_out)
    );

    typedef struct packed {
        logic [1:0]  m;
        logic [15:0] v0;
        logic [15:0] v1;
        logic [15:0] k;
        logic [15:0] e0;
        logic [15:0] e1;
    } vec_t;

    // Expected high half-tick counts: NRZ 2*floor(k*v/65536), RZ floor(k*v/65536).
    localparam vec_t VECS [6] = '{
        '{2'b00, 16'h8000, 16'h4000, 16'd16,   16'd16, 16'd8},
        '{2'b01, 16'h8000, 16'hC000, 16'd16,   16'd8,  16'd12},
        '{2'b00, 16'h0000, 16'hFFFF, 16'd32,   16'd0,  16'd62},
        '{2'b01, 16'h4010, 16'h0001, 16'd64,   16'd16, 16'd0},
        '{2'b00, 16'h0100, 16'h0010, 16'd4096, 16'd32, 16'd2},
        '{2'b01, 16'hFFFF, 16'h2000, 16'd8,    16'd7,  16'd1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_codes(input logic [15:0] v0, input logic [15:0] v1);
        wr(2'd0, v0[7:0]); wr(2'd1, v0[15:8]);
        wr(2'd2, v1[7:0]); wr(2'd3, v1[15:8]);
    endtask

    // Off for one cycle (clears), then k modulator steps with a tick every cycle.
    task automatic run(input logic [1:0] m, input int k, output int c0, output int c1,
                       output logic [15:0] bits);
        c0 = 0; c1 = 0; bits = '0;
        @(negedge clk); mode = 2'b10; tick = 1'b1;
        @(negedge clk); mode = m;
        for (int i = 0; i < 2 * k; i++) begin
            @(negedge clk);
            c0 += int'(pin_out[0]);
            c1 += int'(pin_out[1]);
            if (i < 16) bits[i] = pin_out[0];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0, c1, cnt, unstable;
        logic [15:0] bits;
        logic s;

        // R1: reset drives pins low in an active mode.
        repeat (3) @(negedge clk);
        chk("R1 pins in reset", int'(pin_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pins after reset", int'(pin_out), 0);
        run(2'b00, 8, c0, c1, bits);
        chk("R1 zero codes ch0", c0, 0);
        chk("R1 zero codes ch1", c1, 0);

        // Table walk: R3 R4 R5 R7 R10.
        for (int i = 0; i < 6; i++) begin
            set_codes(VECS[i].v0, VECS[i].v1);
            run(VECS[i].m, int'(VECS[i].k), c0, c1, bits);
            chk($sformatf("R3/R10 vec%0d ch0 (R4 R5 R7)", i), c0, int'(VECS[i].e0));
            chk($sformatf("R3/R10 vec%0d ch1 (R4 R5 R7)", i), c1, int'(VECS[i].e1));
        end

        // R6 and R8: partial run, then re-enable restarts the 0x4010 pattern.
        set_codes(16'h4010, 16'h0000);
        run(2'b01, 3, c0, c1, bits);
        run(2'b01, 8, c0, c1, bits);
        chk("R6 R8 restart pattern", int'(bits[7:0]), 8'h40);
        chk("R6 first eight steps", c0, 2);

        // R2: low byte only staged.
        set_codes(16'h4000, 16'h0000);
        wr(2'd0, 8'hFF);
        run(2'b00, 512, c0, c1, bits);
        chk("R2 staged low byte ignored", c0, 256);
        wr(2'd1, 8'h40);
        run(2'b00, 512, c0, c1, bits);
        chk("R2 high byte commits", c0, 258);

        // R9: gapped ticks; pins hold between ticks.
        set_codes(16'h8000, 16'h0000);
        @(negedge clk); mode = 2'b10;
        @(negedge clk); mode = 2'b00; tick = 1'b0;
        cnt = 0; unstable = 0;
        for (int n = 0; n < 32; n++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            s = pin_out[0];
            cnt += int'(s);
            @(negedge clk);
            if (pin_out[0] != s) unstable++;
        end
        chk("R9 gapped tick count", cnt, 16);
        chk("R9 hold between ticks", unstable, 0);
        tick = 1'b1;

        // R8: off passes port values.
        @(negedge clk); mode = 2'b11; port_in = 2'b10;
        #1 chk("R8 pass-through 10", int'(pin_out), 2);
        port_in = 2'b01;
        #1 chk("R8 pass-through 01", int'(pin_out), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule